// File: doc/BRIEF.md
# Indexed and Indirect Effective Address Unit

This unit turns a 24-bit instruction word into a 15-bit operand address. A three-bit variant field in the word picks the mode. Zero means the address field is used as it is. Codes one to six add one of six 15-bit index registers to the address field. Seven means the address field points at a memory word that holds a new variant and a new address. That word is decoded in the same way, so indirection can chain any number of times before a direct or indexed variant ends it.

The unit owns the six index registers and one 15-bit adder. The adder forms addresses and also counts the registers down. For countdown, an all-ones operand goes into the adder in place of the address field. The registers can be written from the adder, from memory, or from the low bits of the accumulator. A decrement operation writes back the decremented value and flags a branch when the result is non-zero. Indirect words and memory loads come in through a simple read port: a level request, and a valid strobe that carries the data.

Top module: `ea_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and all six index registers hold zero, so an indexed resolve returns the bare address field.
- R2: Op code 0 (resolve) with variant 000 gives `done` one cycle after acceptance, with `ea` equal to word bits 14..0. Opcode bits 23..18 have no effect.
- R3: Resolve with variant 001..110 adds index register 1..6 to bits 14..0, modulo 2^15, and completes one cycle after acceptance.
- R4: Resolve with variant 111 reads memory at bits 14..0. In the returned word, bits 23..21 are the new variant and bits 14..0 the new address; bits 20..15 are ignored. The final address is formed as in R2/R3. With the one-cycle memory used here, `done` comes three cycles after acceptance.
- R5: A fetched variant of 111 starts another read at the new address. `busy` stays high from acceptance until `done`, and the read request and address hold steady until valid returns.
- R6: A request offered while `busy` is high is ignored and changes no index register.
- R7: Op code 1 (decrement) writes register minus one, wrapping 0 to 7FFF. `take` is high with `done` exactly when the new value is non-zero, and `ea` carries bits 14..0 as the branch target.
- R8: Op code 2 (augment) writes register plus bits 14..0, modulo 2^15.
- R9: Op code 3 (load from accumulator) writes `acc_in` into the selected register.
- R10: Op code 4 (load from memory) reads memory at bits 14..0 and writes data bits 14..0 into the selected register. `done` comes three cycles after acceptance with the test memory.
- R11: Register ops with variant 000 or 111 change no register. Op codes 5..7 change no register and complete one cycle after acceptance. `take` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_op | input | 3 | Operation: 0 resolve, 1 decrement, 2 augment, 3 load accumulator, 4 load memory |
| req_word | input | 24 | Instruction word |
| acc_in | input | 15 | Accumulator low bits for op 3 |
| mem_rd_en | output | 1 | Memory read request (level) |
| mem_rd_addr | output | 15 | Memory read address |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 24 | Read data |
| busy | output | 1 | Memory access outstanding |
| done | output | 1 | Completion pulse |
| ea | output | 15 | Effective address or branch target |
| take | output | 1 | Branch flag of a decrement, valid with done |

## Verification
A corrupted index register stays hidden until the next indexed resolve or decrement that names it. It then shows up at once as a wrong `ea` or `take` one cycle after acceptance, which is why each register write is read back through a resolve with a small address field. A wrong control state shows up as a wrong completion latency, or as a read request that never drops. Comparing the cycle of `done` against the expected one, three or five, catches a broken chain within a few cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        OP_RESOLVE = 3'd0,
        OP_DECJMP  = 3'd1,
        OP_AUGMENT = 3'd2,
        OP_LDACC   = 3'd3,
        OP_LDMEM   = 3'd4
    } ea_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IND  = 2'd1,
        ST_LDM  = 2'd2
    } ea_state_e;

    localparam logic [2:0] VAR_DIRECT   = 3'b000;
    localparam logic [2:0] VAR_INDIRECT = 3'b111;

endpackage

// File: rtl/ea_variant_dec.sv
module ea_variant_dec #(
    parameter int SELW = 3
) (
    input  logic [2:0]      vcode,
    output logic            is_ind,
    output logic            has_idx,
    output logic [SELW-1:0] sel
);
    import ea_pkg::*;

    always_comb begin
        is_ind  = (vcode == VAR_INDIRECT);
        has_idx = (vcode != VAR_DIRECT) && (vcode != VAR_INDIRECT);
        sel     = SELW'(vcode - 3'd1);
    end
endmodule

// File: rtl/ea_addr_adder.sv
module ea_addr_adder #(
    parameter int AW = 15
) (
    input  logic [AW-1:0] opa,
    input  logic [AW-1:0] opb,
    output logic [AW-1:0] sum,
    output logic          zero
);
    always_comb begin
        sum  = opa + opb;
        zero = (sum == '0);
    end
endmodule

// File: rtl/ea_index_file.sv
module ea_index_file #(
    parameter int AW   = 15,
    parameter int NIDX = 6,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [SELW-1:0] rd_sel,
    output logic [AW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data
);
    logic [AW-1:0] regs_q [NIDX];

    for (genvar g = 0; g < NIDX; g++) begin : g_reg
        logic [AW-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (wr_en && (wr_sel == SELW'(g))) begin
                reg_d = wr_data;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= reg_d;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NIDX; i++) begin
            if (rd_en && (rd_sel == SELW'(i))) begin
                rd_data = regs_q[i];
            end
        end
    end

    // R11: a write never targets a register outside the file
    a_r11_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_sel) < NIDX));
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int WW   = 24,
    parameter int AW   = 15,
    parameter int NIDX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [WW-1:0] req_word,
    input  logic [AW-1:0] acc_in,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [WW-1:0] mem_rd_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          take
);
    import ea_pkg::*;

    localparam int SELW = $clog2(NIDX);
    localparam int VLO  = AW;
    localparam int VHI  = AW + 2;

    typedef struct packed {
        ea_state_e     st;
        logic [AW-1:0] ptr;
        logic [SELW-1:0] tsel;
        logic          done;
        logic [AW-1:0] ea;
        logic          take;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, ptr: '0, tsel: '0,
                                 done: 1'b0, ea: '0, take: 1'b0};

    ctl_t cq, cd;

    logic [AW-1:0]   i_addr, m_addr;
    logic            i_ind, i_has, m_ind, m_has;
    logic [SELW-1:0] i_sel, m_sel;
    logic            rd_en;
    logic [SELW-1:0] rd_sel;
    logic [AW-1:0]   rd_data;
    logic            wr_en;
    logic [SELW-1:0] wr_sel;
    logic [AW-1:0]   wr_data;
    logic [AW-1:0]   add_b, add_sum;
    logic            add_zero;
    logic            accept;
    logic            unused_bits;

    assign i_addr      = req_word[AW-1:0];
    assign m_addr      = mem_rd_data[AW-1:0];
    assign unused_bits = ^{req_word[WW-1:VHI+1], mem_rd_data[WW-4:AW]};

    ea_variant_dec #(.SELW(SELW)) u_idec (
        .vcode(req_word[VHI:VLO]), .is_ind(i_ind), .has_idx(i_has), .sel(i_sel)
    );

    ea_variant_dec #(.SELW(SELW)) u_mdec (
        .vcode(mem_rd_data[WW-1:WW-3]), .is_ind(m_ind), .has_idx(m_has), .sel(m_sel)
    );

    ea_index_file #(.AW(AW), .NIDX(NIDX), .SELW(SELW)) u_xfile (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
    );

    ea_addr_adder #(.AW(AW)) u_add (
        .opa(rd_data), .opb(add_b), .sum(add_sum), .zero(add_zero)
    );

    // read select and second adder operand
    always_comb begin
        if (cq.st == ST_IDLE) begin
            rd_en  = i_has;
            rd_sel = i_sel;
            add_b  = (req_op == OP_DECJMP) ? '1 : i_addr;
        end else begin
            rd_en  = m_has;
            rd_sel = m_sel;
            add_b  = m_addr;
        end
    end

    assign accept = req_valid && (cq.st == ST_IDLE);

    always_comb begin
        cd      = cq;
        cd.done = 1'b0;
        cd.take = 1'b0;
        wr_en   = 1'b0;
        wr_sel  = i_sel;
        wr_data = add_sum;
        unique case (cq.st)
            ST_IDLE: begin
                if (accept) begin
                    cd.ea = i_addr;
                    case (req_op)
                        OP_RESOLVE: begin
                            if (i_ind) begin
                                cd.st  = ST_IND;
                                cd.ptr = i_addr;
                            end else begin
                                cd.done = 1'b1;
                                cd.ea   = add_sum;
                            end
                        end
                        OP_DECJMP: begin
                            cd.done = 1'b1;
                            wr_en   = i_has;
                            cd.take = i_has && !add_zero;
                        end
                        OP_AUGMENT: begin
                            cd.done = 1'b1;
                            wr_en   = i_has;
                        end
                        OP_LDACC: begin
                            cd.done = 1'b1;
                            wr_en   = i_has;
                            wr_data = acc_in;
                        end
                        OP_LDMEM: begin
                            if (i_has) begin
                                cd.st   = ST_LDM;
                                cd.ptr  = i_addr;
                                cd.tsel = i_sel;
                            end else begin
                                cd.done = 1'b1;
                            end
                        end
                        default: cd.done = 1'b1;
                    endcase
                end
            end
            ST_IND: begin
                if (mem_rd_valid) begin
                    if (m_ind) begin
                        cd.ptr = m_addr;
                    end else begin
                        cd.st   = ST_IDLE;
                        cd.done = 1'b1;
                        cd.ea   = add_sum;
                    end
                end
            end
            ST_LDM: begin
                if (mem_rd_valid) begin
                    wr_en   = 1'b1;
                    wr_sel  = cq.tsel;
                    wr_data = m_addr;
                    cd.st   = ST_IDLE;
                    cd.done = 1'b1;
                    cd.ea   = cq.ptr;
                end
            end
            default: cd = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq <= CTL_RST;
        end else begin
            cq <= cd;
        end
    end

    assign busy        = (cq.st != ST_IDLE);
    assign mem_rd_en   = busy;
    assign mem_rd_addr = cq.ptr;
    assign done        = cq.done;
    assign ea          = cq.ea;
    assign take        = cq.take;

    // R5: an unanswered read keeps its request and address
    a_r5_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

    // R6: completion is only reported once the unit is idle again
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R2: a completion always follows an accepted request or a read return
    a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(req_valid && !busy) || $past(mem_rd_valid)));

    // R11: branch flag only alongside completion
    a_r11_take_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> done);

    // R4: read data only arrives for a read that was requested
    a_r4_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> $past(mem_rd_en));
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [23:0] req_word = '0;
    logic [14:0] acc_in = '0;
    logic        mem_rd_en;
    logic [14:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [23:0] mem_rd_data;
    logic        busy, done, take;
    logic [14:0] ea;

    logic [23:0] mem [16];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_word(req_word), .acc_in(acc_in),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .ea(ea), .take(take)
    );

    // one-cycle memory responder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
        end else if (mem_rd_en && !mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem[mem_rd_addr[3:0]];
        end else begin
            mem_rd_valid <= 1'b0;
        end
    end

    function automatic logic [23:0] iw(input logic [2:0] v, input logic [14:0] a);
        return {6'h2B, v, a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [23:0] w, input logic [14:0] acc,
                       output logic [14:0] r_ea, output logic r_take, output int lat);
        @(negedge clk);
        req_op = op; req_word = w; acc_in = acc; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = -1; r_ea = '0; r_take = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (done) begin
                lat = n; r_ea = ea; r_take = take;
                break;
            end
        end
    endtask

    task automatic read_x(input int k, input logic [14:0] a, input string req,
                          input logic [14:0] exp);
        logic [14:0] e; logic t; int l;
        run(3'd0, iw(3'(k), a), '0, e, t, l);
        chk(e == exp && l == 1, req, $sformatf("index %0d readback", k), int'(e), int'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", int'({busy, done}), 0);
        for (int k = 1; k <= 6; k++) read_x(k, 15'h0005, "R1", 15'h0005);
    endtask

    task automatic t_direct();
        logic [14:0] e; logic t; int l;
        run(3'd0, {6'h3F, 3'b000, 15'h1234}, '0, e, t, l);
        chk(e == 15'h1234, "R2", "direct address", int'(e), 'h1234);
        chk(l == 1, "R2", "direct latency", l, 1);
    endtask

    task automatic t_load_acc();
        logic [14:0] e; logic t; int l;
        logic [14:0] v [6] = '{15'h0101, 15'h0202, 15'h7FF0, 15'h0002, 15'h1000, 15'h0606};
        for (int k = 1; k <= 6; k++) begin
            run(3'd3, iw(3'(k), 15'h0011), v[k-1], e, t, l);
            chk(l == 1, "R9", "load latency", l, 1);
        end
        read_x(1, 15'h0005, "R9", 15'h0106);
        read_x(2, 15'h0005, "R3", 15'h0207);
        read_x(3, 15'h0020, "R3", 15'h0010);
        read_x(6, 15'h0000, "R9", 15'h0606);
    endtask

    task automatic t_indirect();
        logic [14:0] e; logic t; int l;
        run(3'd0, iw(3'b111, 15'h0005), '0, e, t, l);
        chk(e == 15'h0042, "R4", "single indirect", int'(e), 'h42);
        chk(l == 3, "R4", "indirect latency", l, 3);
        run(3'd0, iw(3'b111, 15'h0006), '0, e, t, l);
        chk(e == 15'h0302, "R4", "indirect then index 2", int'(e), 'h302);
    endtask

    task automatic t_chain();
        logic [14:0] e; logic t; int l;
        @(negedge clk);
        req_op = 3'd0; req_word = iw(3'b111, 15'h0007); req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R5", "busy during chain", int'(busy), 1);
        chk(mem_rd_en && mem_rd_addr == 15'h0007, "R5", "first read address",
            int'(mem_rd_addr), 7);
        // R6: offer a register load while busy
        req_op = 3'd3; req_word = iw(3'b001, 15'h0000); acc_in = 15'h1234; req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        l = -1;
        for (int n = 3; n <= 40; n++) begin
            if (n > 3) @(negedge clk);
            if (done) begin l = n; e = ea; break; end
        end
        chk(e == 15'h0111, "R5", "chained indirect", int'(e), 'h111);
        chk(l == 5, "R5", "chain latency", l, 5);
        @(negedge clk);
        chk(!busy && !mem_rd_en, "R5", "read request released", int'(mem_rd_en), 0);
        read_x(1, 15'h0000, "R6", 15'h0101);
    endtask

    task automatic t_decjmp();
        logic [14:0] e; logic t; int l;
        run(3'd1, iw(3'b100, 15'h0ABC), '0, e, t, l);
        chk(t == 1'b1 && e == 15'h0ABC && l == 1, "R7", "2 to 1 branch", int'(t), 1);
        run(3'd1, iw(3'b100, 15'h0ABC), '0, e, t, l);
        chk(t == 1'b0, "R7", "1 to 0 no branch", int'(t), 0);
        read_x(4, 15'h0000, "R7", 15'h0000);
        run(3'd1, iw(3'b100, 15'h0ABC), '0, e, t, l);
        chk(t == 1'b1, "R7", "0 wraps and branches", int'(t), 1);
        read_x(4, 15'h0000, "R7", 15'h7FFF);
    endtask

    task automatic t_augment();
        logic [14:0] e; logic t; int l;
        run(3'd2, iw(3'b101, 15'h0003), '0, e, t, l);
        chk(l == 1 && t == 1'b0, "R8", "augment completes", l, 1);
        read_x(5, 15'h0000, "R8", 15'h1003);
    endtask

    task automatic t_load_mem();
        logic [14:0] e; logic t; int l;
        run(3'd4, iw(3'b110, 15'h0009), '0, e, t, l);
        chk(l == 3, "R10", "memory load latency", l, 3);
        read_x(6, 15'h0000, "R10", 15'h2468);
    endtask

    task automatic t_no_effect();
        logic [14:0] e; logic t; int l;
        run(3'd3, iw(3'b000, 15'h0000), 15'h7777, e, t, l);
        run(3'd3, iw(3'b111, 15'h0000), 15'h7777, e, t, l);
        chk(!mem_rd_en, "R11", "no read for load variant 111", int'(mem_rd_en), 0);
        run(3'd1, iw(3'b000, 15'h0000), '0, e, t, l);
        chk(t == 1'b0, "R11", "decrement without index", int'(t), 0);
        run(3'd5, iw(3'b001, 15'h0321), 15'h7777, e, t, l);
        chk(l == 1 && e == 15'h0321, "R11", "spare op completes", int'(e), 'h321);
        run(3'd7, iw(3'b111, 15'h0004), 15'h7777, e, t, l);
        chk(l == 1 && !busy, "R11", "spare op skips memory", l, 1);
        for (int k = 1; k <= 3; k++) begin
            logic [14:0] exp3 [3] = '{15'h0101, 15'h0202, 15'h7FF0};
            read_x(k, 15'h0000, "R11", exp3[k-1]);
        end
        read_x(6, 15'h0000, "R11", 15'h2468);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[5] = {3'b000, 6'h3F, 15'h0042};
        mem[6] = {3'b010, 6'h2A, 15'h0100};
        mem[7] = {3'b111, 6'h15, 15'h0008};
        mem[8] = {3'b001, 6'h3F, 15'h0010};
        mem[9] = {3'b111, 6'h3F, 15'h2468};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_direct();
        t_load_acc();
        t_indirect();
        t_chain();
        t_decjmp();
        t_augment();
        t_load_mem();
        t_no_effect();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule